// File: doc/BRIEF.md
# Line-Synchronous Pixel Gain Correction Sequencer

This block paces one scan line of pixel data and scales each pixel by its own correction coefficient. A high level on `line_sync` opens a line. The block first gives a one-slot transfer pulse. It then runs pixel slots of 8 clock cycles each for as long as `line_sync` stays high. There is no pixel counter, so the line may be any length.

In each slot the block does three things:
- It raises `coef_strobe` so an outside source can present the coefficient for a later pixel.
- It samples the raw pixel value.
- It drops `conv_done_n` once the corrected value sits in the output register.

A coefficient applies to the result produced four slots after it is sampled. Because of this, the first pixel of a line has no coefficient of its own and passes through at unity gain. The output bus is released to high impedance whenever the active-low read input is high.

When `line_sync` falls, the block does the following:
- It empties its coefficient pipeline.
- It stops loading results.
- It finishes the current slot's strobes and then goes idle.

The analog front end and the converter are not part of this block. The raw value arrives on `raw_in`.

Top module: `pixcorr_line`

## Requirements
- R1: While a line runs, every slot lasts 8 cycles. `coef_strobe` is high in slot cycles 0 to 3 and low in cycles 4 to 7. `conv_done_n` is low in cycles 4 to 7 and high in cycles 0 to 3. Slots repeat with no limit while `line_sync` stays high.
- R2: A line starts when the clock samples `line_sync` high while the block is idle. `xfer_pulse` is then high for exactly 8 cycles, beginning the cycle after that edge. If `line_sync` is still high in the last transfer cycle, slot 0 begins in the next cycle. If it is low, the block returns to idle and raises no strobe.
- R3: `coef_in` is sampled at the clock edge that ends slot cycle 0. `raw_in` is sampled at the edge that ends slot cycle 3. The output register loads at that same edge, so a new result is first visible in the cycle where `conv_done_n` falls.
- R4: The result is min(255, floor(raw × (64 + coef) / 64)). The coefficient is an unsigned 7-bit value, and coefficient 0 gives unity gain.
- R5: The result loaded in slot k (k ≥ 4) uses the raw value of slot k and the coefficient sampled in slot k−4.
- R6: In slots 0 to 2 of a line the output register keeps its value. In slot 3, which carries the first pixel, it loads the raw value unscaled.
- R7: When `line_sync` is sampled low during a line, all of the following hold:
  - From that cycle on, no coefficient is sampled and no result is loaded.
  - Every pending coefficient is discarded.
  - The current slot completes its strobe pattern, and the block is then idle, with `coef_strobe` low and `conv_done_n` high.
  - A following line behaves exactly like the first line after reset.
- R8: With `rd_n` high, `pix_out` is high impedance and `pix_oe` is 0. With `rd_n` low, `pix_out` drives the output register and `pix_oe` is 1. `rd_n` has no effect on the register contents.
- R9: After reset, `xfer_pulse` = 0, `coef_strobe` = 0, `conv_done_n` = 1 and the output register holds 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; one pixel slot is 8 periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sync | input | 1 | High for the duration of a scan line |
| coef_in | input | 7 | Correction coefficient, sampled once per slot |
| raw_in | input | 8 | Uncorrected pixel value |
| rd_n | input | 1 | Active-low output read enable |
| xfer_pulse | output | 1 | Transfer pulse at line start |
| coef_strobe | output | 1 | Coefficient fetch strobe, high in the first half-slot |
| conv_done_n | output | 1 | Low while the corrected result is valid |
| pix_out | output | 8 | Corrected pixel bus, high impedance while `rd_n` is high |
| pix_oe | output | 1 | High while `pix_out` is driven |

## Verification
The transfer pulse rises one cycle after `line_sync` is first sampled high. Slot 0 then begins nine cycles after that sampling edge. A result loads at the edge that ends slot cycle 3, and the coefficient it uses was sampled four slots earlier.

The bench keeps its own count of negative clock edges from the cycle in which it raised `line_sync`. It drives each slot's coefficient and raw value in slot cycle 0. It reads the bus once in cycle 3, where the old value must still be present, and once in cycle 4, where the new value is due. Its expected values come from a model of the scaling formula that indexes the coefficients it drove four slots back.

// File: rtl/pixcorr_pkg.sv
package pixcorr_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_XFER = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/pixcorr_timing.sv
module pixcorr_timing
  import pixcorr_pkg::*;
#(
  parameter int SLOT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_sync,
  output logic xfer_o,
  output logic strobe_o,
  output logic eoc_n_o,
  output logic cap_en_o,
  output logic upd_en_o,
  output logic flush_o
);

  localparam int CW = $clog2(SLOT_CYC);
  localparam logic [CW-1:0] LAST   = CW'(SLOT_CYC - 1);
  localparam logic [CW-1:0] HALF   = CW'(SLOT_CYC / 2);
  localparam logic [CW-1:0] CAP_PH = '0;
  localparam logic [CW-1:0] UPD_PH = CW'(SLOT_CYC / 2 - 1);

  seq_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            stop_q, stop_d;
  logic            live;

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    stop_d  = stop_q;
    case (state_q)
      SEQ_IDLE: begin
        cnt_d  = '0;
        stop_d = 1'b0;
        if (line_sync) state_d = SEQ_XFER;
      end
      SEQ_XFER: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          cnt_d   = '0;
          state_d = line_sync ? SEQ_RUN : SEQ_IDLE;
        end
      end
      SEQ_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (!line_sync) stop_d = 1'b1;
        if (cnt_q == LAST) begin
          cnt_d = '0;
          if (stop_q || !line_sync) begin
            state_d = SEQ_IDLE;
            stop_d  = 1'b0;
          end
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
        stop_d  = 1'b0;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      stop_q  <= stop_d;
    end
  end

  assign live     = (state_q == SEQ_RUN) && line_sync && !stop_q;
  assign xfer_o   = (state_q == SEQ_XFER);
  assign strobe_o = (state_q == SEQ_RUN) && (cnt_q < HALF);
  assign eoc_n_o  = !((state_q == SEQ_RUN) && (cnt_q >= HALF));
  assign cap_en_o = live && (cnt_q == CAP_PH);
  assign upd_en_o = live && (cnt_q == UPD_PH);
  assign flush_o  = !live;

  // R1
  strobe_eoc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_o && !eoc_n_o));

  // R1
  strobe_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> !eoc_n_o);

  // R2
  first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_o && cnt_q == LAST && line_sync) |=> (strobe_o && !xfer_o));

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN && !line_sync && cnt_q == LAST) |=> (!strobe_o && eoc_n_o));

endmodule

// File: rtl/pixcorr_coef_line.sv
module pixcorr_coef_line #(
  parameter int COEF_W = 7,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              flush,
  input  logic [COEF_W-1:0] coef_in,
  output logic [COEF_W-1:0] old_coef,
  output logic              old_v,
  output logic              pre_v
);

  logic [COEF_W-1:0] cap_q;
  logic              cap_v;
  logic [COEF_W-1:0] stg_q [LAT];
  logic [LAT-1:0]    stg_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      cap_v <= 1'b0;
    end else if (flush) begin
      cap_v <= 1'b0;
    end else if (cap_en) begin
      cap_q <= coef_in;
      cap_v <= 1'b1;
    end
  end

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    logic [COEF_W-1:0] src_c;
    logic              src_v;
    if (i == 0) begin : g_head
      assign src_c = cap_q;
      assign src_v = cap_v;
    end else begin : g_body
      assign src_c = stg_q[i-1];
      assign src_v = stg_v[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[i] <= '0;
        stg_v[i] <= 1'b0;
      end else if (flush) begin
        stg_v[i] <= 1'b0;
      end else if (cap_en) begin
        stg_q[i] <= src_c;
        stg_v[i] <= src_v;
      end
    end
  end

  assign old_coef = stg_q[LAT-1];
  assign old_v    = stg_v[LAT-1];
  assign pre_v    = stg_v[LAT-2];

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!cap_v && stg_v == '0));

  // R5
  fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    old_v |-> pre_v);

endmodule

// File: rtl/pixcorr_gain.sv
module pixcorr_gain #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 7
) (
  input  logic [PIX_W-1:0]  raw,
  input  logic [COEF_W-1:0] coef,
  output logic [PIX_W-1:0]  y
);

  localparam int FRAC   = COEF_W - 1;
  localparam int PROD_W = PIX_W + COEF_W + 1;
  localparam logic [PROD_W-1:0] UNITY = PROD_W'(1) << FRAC;

  logic [PROD_W-1:0] mult;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] scaled;

  always_comb begin
    mult   = UNITY + PROD_W'(coef);
    prod   = PROD_W'(raw) * mult;
    scaled = prod >> FRAC;
    if (|scaled[PROD_W-1:PIX_W]) y = '1;
    else                         y = scaled[PIX_W-1:0];
  end

  // R4
  always_comb begin
    gain_monotone_chk: assert (y >= raw);
  end

endmodule

// File: rtl/pixcorr_line.sv
module pixcorr_line #(
  parameter int PIX_W    = 8,
  parameter int COEF_W   = 7,
  parameter int SLOT_CYC = 8,
  parameter int LAT      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_sync,
  input  logic [COEF_W-1:0] coef_in,
  input  logic [PIX_W-1:0]  raw_in,
  input  logic              rd_n,
  output logic              xfer_pulse,
  output logic              coef_strobe,
  output logic              conv_done_n,
  output logic [PIX_W-1:0]  pix_out,
  output logic              pix_oe
);

  logic              rst_m, rst_s;
  logic              cap_en, upd_en, flush;
  logic [COEF_W-1:0] old_coef, sel_coef;
  logic              old_v, pre_v;
  logic [PIX_W-1:0]  gained;
  logic [PIX_W-1:0]  out_q, out_d;
  logic              out_en;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  pixcorr_timing #(.SLOT_CYC(SLOT_CYC)) u_timing (
    .clk      (clk),
    .rst_n    (rst_s),
    .line_sync(line_sync),
    .xfer_o   (xfer_pulse),
    .strobe_o (coef_strobe),
    .eoc_n_o  (conv_done_n),
    .cap_en_o (cap_en),
    .upd_en_o (upd_en),
    .flush_o  (flush)
  );

  pixcorr_coef_line #(.COEF_W(COEF_W), .LAT(LAT)) u_coef (
    .clk     (clk),
    .rst_n   (rst_s),
    .cap_en  (cap_en),
    .flush   (flush),
    .coef_in (coef_in),
    .old_coef(old_coef),
    .old_v   (old_v),
    .pre_v   (pre_v)
  );

  assign sel_coef = old_v ? old_coef : '0;

  pixcorr_gain #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_gain (
    .raw (raw_in),
    .coef(sel_coef),
    .y   (gained)
  );

  // output register: next value and enable
  assign out_en = upd_en && (old_v || pre_v);
  assign out_d  = gained;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  assign pix_oe  = !rd_n;
  assign pix_out = rd_n ? 'z : out_q;

  // R7
  no_load_when_low_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !line_sync |=> $stable(out_q));

  // R3
  load_at_eoc_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(out_q) |-> $fell(conv_done_n));

endmodule

// File: tb/pixcorr_line_test.sv
module pixcorr_line_test;

  localparam int PERIOD = 10;
  localparam int NV     = 12;
  // {coef[14:8], raw[7:0]}
  localparam logic [14:0] VEC [NV] = '{
    {7'd5,   8'd10},  {7'd0,  8'd100}, {7'd127, 8'd200}, {7'd64, 8'd40},
    {7'd1,   8'd64},  {7'd32, 8'd255}, {7'd0,   8'd200}, {7'd10, 8'd100},
    {7'd3,   8'd0},   {7'd127,8'd255}, {7'd2,   8'd128}, {7'd50, 8'd33}
  };

  logic       clk = 1'b0;
  logic       rst_n, line_sync, rd_n;
  logic [6:0] coef_in;
  logic [7:0] raw_in;
  logic       xfer_pulse, coef_strobe, conv_done_n, pix_oe;
  logic [7:0] pix_out;

  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;
  logic [7:0] last_out;
  logic [6:0] line_coef [32];

  always #(PERIOD/2) clk = ~clk;

  pixcorr_line uut (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .coef_in(coef_in),
    .raw_in(raw_in), .rd_n(rd_n), .xfer_pulse(xfer_pulse),
    .coef_strobe(coef_strobe), .conv_done_n(conv_done_n),
    .pix_out(pix_out), .pix_oe(pix_oe)
  );

  function automatic logic [7:0] model(logic [7:0] r, logic [6:0] c);
    int p;
    p = (int'(r) * (64 + int'(c))) / 64;
    return (p > 255) ? 8'hFF : 8'(p);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // raise line_sync and walk through the transfer pulse; returns at slot 0 cycle 0
  task automatic start_line();
    line_sync = 1'b1;
    tick(1);
    check("R2 transfer pulse first cycle", xfer_pulse, 1);
    tick(7);
    check("R2 transfer pulse eighth cycle", xfer_pulse, 1);
    tick(1);
    check("R2 transfer pulse ended", xfer_pulse, 0);
    check("R2 slot 0 strobe", coef_strobe, 1);
  endtask

  // one slot starting at cycle 0; returns at next slot cycle 0
  task automatic do_slot(int k, int idx);
    logic [7:0] exp;
    coef_in      = VEC[idx][14:8];
    raw_in       = VEC[idx][7:0];
    line_coef[k] = coef_in;
    check("R1 strobe high cycle 0", coef_strobe, 1);
    check("R1 eoc high cycle 0", conv_done_n, 1);
    tick(3);
    check("R3 old value held in cycle 3", pix_out, last_out);
    tick(1);
    check("R1 strobe low cycle 4", coef_strobe, 0);
    check("R1 eoc low cycle 4", conv_done_n, 0);
    if (k < 3) begin
      exp = last_out;
      check("R6 fill slot holds output", pix_out, exp);
    end else if (k == 3) begin
      exp = raw_in;
      check("R6 first pixel unity", pix_out, exp);
    end else begin
      exp = model(raw_in, line_coef[k-4]);
      check("R4/R5 corrected value", pix_out, exp);
    end
    last_out = exp;
    tick(4);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; line_sync = 1'b0; rd_n = 1'b0; coef_in = '0; raw_in = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    check("R9 reset transfer pulse", xfer_pulse, 0);
    check("R9 reset strobe", coef_strobe, 0);
    check("R9 reset eoc", conv_done_n, 1);
    check("R9 reset output", pix_out, 0);
    check("R8 driven when read low", pix_oe, 1);
    last_out = 8'd0;

    // line 1: table walk
    start_line();
    for (int k = 0; k < NV; k++) do_slot(k, k);

    // R7: drop line_sync in cycle 0 of a slot
    check("R7 slot started", coef_strobe, 1);
    line_sync = 1'b0;
    raw_in    = 8'd77;
    tick(4);
    check("R7 slot completes eoc", conv_done_n, 0);
    check("R7 no load after stop", pix_out, last_out);
    tick(4);
    check("R7 idle strobe", coef_strobe, 0);
    check("R7 idle eoc", conv_done_n, 1);
    tick(8);
    check("R7 still idle", coef_strobe, 0);

    // R2: short line_sync pulse
    line_sync = 1'b1;
    tick(1);
    line_sync = 1'b0;
    check("R2 short pulse transfer", xfer_pulse, 1);
    tick(7);
    check("R2 short pulse eighth cycle", xfer_pulse, 1);
    tick(1);
    check("R2 short pulse ends", xfer_pulse, 0);
    check("R2 short pulse no strobe", coef_strobe, 0);
    check("R2 short pulse eoc high", conv_done_n, 1);
    tick(8);
    check("R2 short pulse stays idle", coef_strobe, 0);
    check("R2 short pulse output kept", pix_out, last_out);

    // line 2: restart after flush (R7), different vectors
    start_line();
    for (int k = 0; k < 6; k++) do_slot(k, (k + 6) % NV);

    // R8: read disabled across a load
    rd_n = 1'b1;
    #1;
    check("R8 released when read high", pix_oe, 0);
    coef_in      = VEC[0][14:8];
    raw_in       = VEC[0][7:0];
    line_coef[6] = coef_in;
    tick(4);
    check("R8 still released", pix_oe, 0);
    rd_n = 1'b0;
    #1;
    check("R8 driven again", pix_oe, 1);
    check("R8 register loaded while released", pix_out,
          model(VEC[0][7:0], line_coef[2]));
    tick(4);
    line_sync = 1'b0;
    tick(16);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule